// File: doc/BRIEF.md
# Three-Door Lock Controller

This block drives the locks of three doors from a record of which doors have been tried. Each door has a level input that is high while the door stands open. Each door also has a lock output, where 1 means locked and 0 means unlocked. The block keeps one sticky flag per door. A flag is set in the first cycle in which that door's open input is sampled high. The locks depend only on these flags and never on whether a door is open or closed right now.

A player may open and close one door as often as they like. When a second, different door is opened, the single door not yet tried is locked. It stays locked until the synchronous reset clears every flag and lock. The number of doors and the number of distinct doors that triggers the lock are parameters, with defaults of three and two. All inputs are taken to be synchronous to the clock.

Top module: `door_lock_ctrl`

## Requirements
- R1: After a cycle with `rst` high, every bit of `door_lock` is 0 (unlocked). A 1 on `door_lock[i]` means door i is locked.
- R2: Door i is recorded as tried at the first rising clock edge at which `door_open[i]` is sampled high. Any lock that this record causes is visible on `door_lock` right after that same edge.
- R3: `rst` is synchronous and active-high and wins over the door inputs. A door open during a reset cycle is not recorded, and the locks read 0 afterwards.
- R4: Once two distinct doors have been tried, exactly the one untried door has `door_lock` = 1 and the two tried doors read 0. At no time is more than one lock bit high.
- R5: Opening and closing one and the same door any number of times, with no other door opened, leaves all locks at 0.
- R6: After the lock appears, the open or closed levels of the two tried doors do not change `door_lock`.
- R7: A locked door stays locked until reset. Raising its own open input while it is locked records nothing and changes no output.
- R8: If two open inputs are sampled high in the same cycle with nothing tried before, both doors are recorded. The third door locks right after that edge.
- R9: If all three open inputs are sampled high in one cycle with nothing tried before, all three are recorded and no door locks. The locks stay 0 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears history and locks |
| door_open | input | 3 | Bit i is high while door i is open |
| door_lock | output | 3 | Bit i is 1 when door i is locked |

## Verification
A wrong history flag shows up at the ports at once. The lock output is a direct function of the flags, so it is visible in the cycle right after the edge that stored the flag. A flag set by mistake locks the wrong door, or locks too early after a single door has been tried. A flag that fails to set leaves every door unlocked after the second distinct door. The bench therefore compares `door_lock` with a model after every clock edge. It drives random patterns of repeated single-door opening, paired openings and resets, together with directed sequences for each corner case.

// File: rtl/door_lock_pkg.sv
package door_lock_pkg;
  localparam int unsigned DEF_DOORS = 3;
  localparam int unsigned DEF_LIMIT = 2;
endpackage

// File: rtl/door_history.sv
module door_history #(
  parameter int unsigned N_DOORS = door_lock_pkg::DEF_DOORS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec_en,
  input  logic [N_DOORS-1:0] door_open,
  output logic [N_DOORS-1:0] tried
);
  for (genvar i = 0; i < N_DOORS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        tried[i] <= 1'b0;
      end else if (rec_en && door_open[i]) begin
        tried[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_decide.sv
module lock_decide #(
  parameter int unsigned N_DOORS   = door_lock_pkg::DEF_DOORS,
  parameter int unsigned TRY_LIMIT = door_lock_pkg::DEF_LIMIT
) (
  input  logic [N_DOORS-1:0] tried,
  output logic               frozen,
  output logic [N_DOORS-1:0] lock
);
  localparam int unsigned CNT_W = $clog2(N_DOORS + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(TRY_LIMIT);

  logic [CNT_W-1:0] n_tried;

  always_comb begin
    n_tried = '0;
    for (int i = 0; i < N_DOORS; i++) begin
      n_tried = n_tried + CNT_W'(tried[i]);
    end
  end

  assign frozen = (n_tried >= LIMIT_C);
  assign lock   = frozen ? ~tried : '0;
endmodule

// File: rtl/door_lock_ctrl.sv
module door_lock_ctrl #(
  parameter int unsigned N_DOORS   = door_lock_pkg::DEF_DOORS,
  parameter int unsigned TRY_LIMIT = door_lock_pkg::DEF_LIMIT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_DOORS-1:0] door_open,
  output logic [N_DOORS-1:0] door_lock
);
  logic [N_DOORS-1:0] tried;
  logic               frozen;

  door_history #(.N_DOORS(N_DOORS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rec_en   (!frozen),
    .door_open(door_open),
    .tried    (tried)
  );

  lock_decide #(.N_DOORS(N_DOORS), .TRY_LIMIT(TRY_LIMIT)) u_dec (
    .tried (tried),
    .frozen(frozen),
    .lock  (door_lock)
  );
endmodule

// File: rtl/door_lock_chk.sv
module door_lock_chk #(
  parameter int unsigned N_DOORS = door_lock_pkg::DEF_DOORS
) (
  input logic               clk,
  input logic               rst,
  input logic [N_DOORS-1:0] door_open,
  input logic [N_DOORS-1:0] door_lock
);
  AST_RST_UNLOCKS: assert property (@(posedge clk) rst |=> (door_lock == '0)); // R1
  AST_ONE_LOCK_MAX: assert property (@(posedge clk) disable iff (rst) $onehot0(door_lock)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) (|door_lock) |=> $stable(door_lock)); // R7
  AST_LOCK_NOT_ENTERED: assert property (@(posedge clk) disable iff (rst)
    $rose(|door_lock) |-> ((door_lock & $past(door_open)) == '0)); // R4
endmodule

bind door_lock_ctrl door_lock_chk #(.N_DOORS(N_DOORS)) u_chk (
  .clk(clk), .rst(rst), .door_open(door_open), .door_lock(door_lock)
);

// File: tb/sim_door_lock_ctrl.sv
module sim_door_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] door_open = 3'b000;
  logic [2:0] door_lock;

  int checks = 0;
  int fails  = 0;
  logic [2:0] m_tried = 3'b000;

  door_lock_ctrl u0 (.clk(clk), .rst(rst), .door_open(door_open), .door_lock(door_lock));

  always #2 clk = ~clk;

  function automatic int ones3(input logic [2:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]);
  endfunction

  function automatic logic [2:0] exp_lock(input logic [2:0] t);
    return (ones3(t) >= 2) ? ~t : 3'b000;
  endfunction

  function automatic logic [2:0] next_tried(input logic [2:0] t, input logic r, input logic [2:0] o);
    if (r) return 3'b000;
    if (ones3(t) >= 2) return t;
    return t | o;
  endfunction

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s door_lock=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic [2:0] o, input string tag);
    @(negedge clk);
    rst = r;
    door_open = o;
    @(posedge clk);
    m_tried = next_tried(m_tried, r, o);
    #1;
    chk(tag, door_lock, exp_lock(m_tried));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    step(1'b1, 3'b000, "R1 reset");
    step(1'b1, 3'b000, "R1 reset");
    chk("R1 reset state", door_lock, 3'b000);
    // R5: one door many times
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 3'b001, "R5 same door open");
      step(1'b0, 3'b000, "R5 same door closed");
    end
    chk("R5 no lock", door_lock, 3'b000);
    // R2 / R4: second distinct door locks the third right after the edge
    step(1'b0, 3'b100, "R2 second door edge");
    chk("R4 untried door 1 locked", door_lock, 3'b010);
    // R6: levels of tried doors irrelevant
    step(1'b0, 3'b101, "R6 both open");
    step(1'b0, 3'b000, "R6 both closed");
    chk("R6 lock unchanged", door_lock, 3'b010);
    // R7: locked door's own input ignored
    step(1'b0, 3'b010, "R7 locked door input");
    step(1'b0, 3'b111, "R7 all inputs");
    chk("R7 still locked", door_lock, 3'b010);
    // R3: reset wins over door input
    step(1'b1, 3'b011, "R3 reset with doors open");
    chk("R3 unlocked", door_lock, 3'b000);
    step(1'b0, 3'b100, "R3 door2 after reset");
    chk("R3 no lock from reset-cycle doors", door_lock, 3'b000);
    // R8: simultaneous pair
    step(1'b1, 3'b000, "R8 reset");
    step(1'b0, 3'b110, "R8 pair opened");
    chk("R8 door0 locked", door_lock, 3'b001);
    // R9: all three at once
    step(1'b1, 3'b000, "R9 reset");
    step(1'b0, 3'b111, "R9 triple");
    chk("R9 none locked", door_lock, 3'b000);
    step(1'b0, 3'b010, "R9 stays unlocked");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      int p;
      logic [2:0] o;
      r = int'($urandom % 100);
      p = int'($urandom % 10);
      if (p < 6)      o = 3'b001 << ($urandom % 3);
      else if (p < 8) o = 3'b000;
      else if (p < 9) o = ~(3'b001 << ($urandom % 3));
      else            o = 3'b111;
      step(r < 4, o, "R4 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule